// File: doc/BRIEF.md
# Programmed I/O Ready-Flag Unit

This block sits beside a small accumulator processor and carries out its I/O transfer instructions. It serves two input devices and two output devices. Each device owns a ready flag. A device raises its flag when it holds a byte for the processor (input) or when it can take a new byte (output). Software tests, transfers and clears these flags through a 5-bit command field that arrives with each I/O instruction.

The core presents the field together with a one-cycle execute strobe. In that same cycle the unit returns three things: a skip request that advances the program counter, an input byte with a load strobe for the accumulator, and a clear strobe for the accumulator. Output bytes are taken from the accumulator value on that edge. On the following cycle the selected output device sees the byte and a one-cycle write strobe. The three micro-operations in the field can be combined freely, so one instruction can read and clear a flag, or write and clear a flag.

Top module: `iot_flag_unit`

## Requirements
- R1: After reset, all four ready flags are 0, every output write strobe is 0 and the output byte is 0.
- R2: A one-cycle pulse on a device's flag-set input makes that device's ready flag read 1 from the next cycle on, until software clears it.
- R3: Field bit 4 picks the direction (0 input, 1 output) and bit 3 picks device 0 or 1. With bit 0 set, skipReq is 1 in the execute cycle exactly when the selected device's flag is 1. Otherwise skipReq is 0.
- R4: For input with bit 1 set, acLoad is 1 in the execute cycle and acData carries the selected input device's byte.
- R5: For output with bit 1 set, acClear is 1 in the execute cycle. On the next cycle outData holds the accumulator value of that cycle and outStrobe has exactly the selected device's bit set, for one cycle only.
- R6: With bit 2 set, the selected device's flag reads 0 from the next cycle on. The other three flags are unchanged.
- R7: An input instruction with bits 1 and 2 both set delivers the byte in its execute cycle and leaves the flag cleared afterwards.
- R8: When a device's flag-set pulse coincides with a software clear of that same flag, the flag ends up 1.
- R9: While iotValid is 0, the field has no effect. skipReq, acLoad and acClear stay 0, no flag is cleared and no strobe is issued.
- R10: An input instruction never raises acClear or an output strobe. An output instruction never raises acLoad.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| iotValid | input | 1 | Execute cycle of an I/O instruction |
| iotField | input | 5 | Command field: [4] direction, [3] device, [2] clear flag, [1] transfer, [0] skip |
| acIn | input | 8 | Accumulator value from the core |
| skipReq | output | 1 | Advance PC by one |
| acLoad | output | 1 | Load acData into the accumulator |
| acData | output | 8 | Selected input device byte |
| acClear | output | 1 | Clear the accumulator |
| inData | input | 16 | Input device bytes, device n at [8n+7:8n] |
| inReadySet | input | 2 | Per input device: flag-set pulse |
| outReadySet | input | 2 | Per output device: flag-set pulse |
| outData | output | 8 | Byte latched for the output devices |
| outStrobe | output | 2 | Per output device: one-cycle write strobe |
| inReady | output | 2 | Input device ready flags |
| outReady | output | 2 | Output device ready flags |

## Verification
Directed sequences walk each device through set, skip-test, transfer and clear. This shows whether the direction and device bits route to the right flag and not to its neighbour. Combined commands (read with clear, write with clear) and a flag-set pulse landing on the clear cycle separate a correct ordering from one that loses the event or the data. A random phase mixes execute and idle cycles with random fields and random device pulses. Its outputs are compared each clock with a behavioural model, which exposes decoding that leaks across directions or acts while no instruction is executing.

// File: rtl/iot_pkg.sv
package iot_pkg;
  localparam int DEV_CNT = 2;
  localparam int DATA_W  = 8;
  localparam int SEL_W   = (DEV_CNT > 1) ? $clog2(DEV_CNT) : 1;
  localparam int FIELD_W = 5;
  // command field bit positions (decoded by the core's instruction format)
  localparam int B_SKIP = 0;
  localparam int B_XFER = 1;
  localparam int B_CLR  = 2;
  localparam int B_DEV  = 3;
  localparam int B_DIR  = 4;

  typedef struct packed {
    logic [DEV_CNT-1:0] inClr;
    logic [DEV_CNT-1:0] outClr;
    logic [DEV_CNT-1:0] outLoad;
    logic [SEL_W-1:0]   devSel;
  } iotStrobes_t;
endpackage

// File: rtl/iot_ctrl.sv
module iot_ctrl
  import iot_pkg::*;
(
  input  logic               iotValid,
  input  logic [FIELD_W-1:0] iotField,
  input  logic [DEV_CNT-1:0] inReady,
  input  logic [DEV_CNT-1:0] outReady,
  output iotStrobes_t        strobes,
  output logic               skipReq,
  output logic               acLoad,
  output logic               acClear
);
  logic               dirOut;
  logic [SEL_W-1:0]   sel;
  logic [DEV_CNT-1:0] devHot;

  always_comb begin
    dirOut = iotField[B_DIR];
    sel    = iotField[B_DEV +: SEL_W];
    devHot = iotValid ? (DEV_CNT'(1) << sel) : '0;

    strobes.devSel  = sel;
    strobes.inClr   = (!dirOut && iotField[B_CLR])  ? devHot : '0;
    strobes.outClr  = ( dirOut && iotField[B_CLR])  ? devHot : '0;
    strobes.outLoad = ( dirOut && iotField[B_XFER]) ? devHot : '0;

    skipReq = iotValid && iotField[B_SKIP] &&
              (dirOut ? outReady[sel] : inReady[sel]);
    acLoad  = iotValid && !dirOut && iotField[B_XFER];
    acClear = iotValid &&  dirOut && iotField[B_XFER];
  end
endmodule

// File: rtl/iot_dpath.sv
module iot_dpath
  import iot_pkg::*;
(
  input  logic                      clk,
  input  logic                      rstN,
  input  iotStrobes_t               strobes,
  input  logic [DATA_W-1:0]         acIn,
  input  logic [DEV_CNT*DATA_W-1:0] inData,
  input  logic [DEV_CNT-1:0]        inReadySet,
  input  logic [DEV_CNT-1:0]        outReadySet,
  output logic [DATA_W-1:0]         acData,
  output logic [DATA_W-1:0]         outData,
  output logic [DEV_CNT-1:0]        outStrobe,
  output logic [DEV_CNT-1:0]        inReady,
  output logic [DEV_CNT-1:0]        outReady
);
  // per-device flags: a device event wins over a software clear
  for (genvar d = 0; d < DEV_CNT; d++) begin : g_flag
    always_ff @(posedge clk) begin
      if (!rstN)                  inReady[d] <= 1'b0;
      else if (inReadySet[d])     inReady[d] <= 1'b1;
      else if (strobes.inClr[d])  inReady[d] <= 1'b0;
    end
    always_ff @(posedge clk) begin
      if (!rstN)                  outReady[d] <= 1'b0;
      else if (outReadySet[d])    outReady[d] <= 1'b1;
      else if (strobes.outClr[d]) outReady[d] <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      outData   <= '0;
      outStrobe <= '0;
    end else begin
      outStrobe <= strobes.outLoad;
      if (|strobes.outLoad) outData <= acIn;
    end
  end

  assign acData = inData[strobes.devSel*DATA_W +: DATA_W];
endmodule

// File: rtl/iot_flag_unit.sv
module iot_flag_unit
  import iot_pkg::*;
(
  input  logic                      clk,
  input  logic                      rstN,
  input  logic                      iotValid,
  input  logic [FIELD_W-1:0]        iotField,
  input  logic [DATA_W-1:0]         acIn,
  output logic                      skipReq,
  output logic                      acLoad,
  output logic [DATA_W-1:0]         acData,
  output logic                      acClear,
  input  logic [DEV_CNT*DATA_W-1:0] inData,
  input  logic [DEV_CNT-1:0]        inReadySet,
  input  logic [DEV_CNT-1:0]        outReadySet,
  output logic [DATA_W-1:0]         outData,
  output logic [DEV_CNT-1:0]        outStrobe,
  output logic [DEV_CNT-1:0]        inReady,
  output logic [DEV_CNT-1:0]        outReady
);
  iotStrobes_t strobes;

  iot_ctrl u_ctrl (
    .iotValid (iotValid),
    .iotField (iotField),
    .inReady  (inReady),
    .outReady (outReady),
    .strobes  (strobes),
    .skipReq  (skipReq),
    .acLoad   (acLoad),
    .acClear  (acClear)
  );

  iot_dpath u_dpath (
    .clk         (clk),
    .rstN        (rstN),
    .strobes     (strobes),
    .acIn        (acIn),
    .inData      (inData),
    .inReadySet  (inReadySet),
    .outReadySet (outReadySet),
    .acData      (acData),
    .outData     (outData),
    .outStrobe   (outStrobe),
    .inReady     (inReady),
    .outReady    (outReady)
  );
endmodule

// File: rtl/iot_flag_unit_chk.sv
module iot_flag_unit_chk
  import iot_pkg::*;
(
  input logic               clk,
  input logic               rstN,
  input logic               iotValid,
  input logic [FIELD_W-1:0] iotField,
  input logic               skipReq,
  input logic               acLoad,
  input logic               acClear,
  input logic [DATA_W-1:0]  outData,
  input logic [DEV_CNT-1:0] outStrobe,
  input logic [DEV_CNT-1:0] inReadySet,
  input logic [DEV_CNT-1:0] inReady,
  input logic [DEV_CNT-1:0] outReady
);
  a_r9_idle_quiet: assert property (@(posedge clk) disable iff (!rstN)
    !iotValid |-> (!skipReq && !acLoad && !acClear));

  a_r5_strobe_onehot: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(outStrobe));

  a_r5_strobe_cause: assert property (@(posedge clk) disable iff (!rstN)
    iotValid && iotField[B_DIR] && iotField[B_XFER] |=> (|outStrobe));

  a_r10_dir_exclusive: assert property (@(posedge clk) disable iff (!rstN)
    !(acLoad && (acClear || (|outStrobe && $past(!iotField[B_DIR] && iotValid)))));

  for (genvar d = 0; d < DEV_CNT; d++) begin : g_chk
    a_r2_set_flag: assert property (@(posedge clk) disable iff (!rstN)
      inReadySet[d] |=> inReady[d]);

    a_r6_clear_flag: assert property (@(posedge clk) disable iff (!rstN)
      (iotValid && !iotField[B_DIR] && iotField[B_CLR] &&
       (int'(iotField[B_DEV +: SEL_W]) == d) && !inReadySet[d]) |=> !inReady[d]);

    a_r9_no_clear_idle: assert property (@(posedge clk) disable iff (!rstN)
      (!iotValid && outReady[d]) |=> outReady[d]);
  end
endmodule

bind iot_flag_unit iot_flag_unit_chk u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .iotValid   (iotValid),
  .iotField   (iotField),
  .skipReq    (skipReq),
  .acLoad     (acLoad),
  .acClear    (acClear),
  .outData    (outData),
  .outStrobe  (outStrobe),
  .inReadySet (inReadySet),
  .inReady    (inReady),
  .outReady   (outReady)
);

// File: tb/test_iot_flag_unit.sv
`timescale 1ns/1ps
module test_iot_flag_unit;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        iotValid = 1'b0;
  logic [4:0]  iotField = '0;
  logic [7:0]  acIn = '0;
  logic        skipReq, acLoad, acClear;
  logic [7:0]  acData, outData;
  logic [15:0] inData = 16'h0000;
  logic [1:0]  inReadySet = '0, outReadySet = '0;
  logic [1:0]  outStrobe, inReady, outReady;

  int nChecks = 0;
  int nFails  = 0;
  bit done    = 1'b0;

  // behavioural model state
  int mIn[2];
  int mOut[2];
  int mStrobe = 0;
  int mOutData = 0;

  always #2.5 clk = ~clk;

  iot_flag_unit i_iot_flag_unit (
    .clk(clk), .rstN(rstN), .iotValid(iotValid), .iotField(iotField),
    .acIn(acIn), .skipReq(skipReq), .acLoad(acLoad), .acData(acData),
    .acClear(acClear), .inData(inData), .inReadySet(inReadySet),
    .outReadySet(outReadySet), .outData(outData), .outStrobe(outStrobe),
    .inReady(inReady), .outReady(outReady)
  );

  task automatic chk(input string tag, input string name, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, name, act, exp);
    end
  endtask

  // one clock: apply inputs at negedge, compare 1 ns later, advance model
  task automatic step(input logic v, input logic [4:0] f, input logic [7:0] a,
                      input logic [1:0] iSet, input logic [1:0] oSet, input string tag);
    int sel, eSkip, eLoad, eClr, nStr;
    bit dOut;
    @(negedge clk);
    iotValid = v; iotField = f; acIn = a; inReadySet = iSet; outReadySet = oSet;
    #1;
    sel  = f[3];
    dOut = f[4];
    eSkip = (v && f[0] && (dOut ? mOut[sel] : mIn[sel]) != 0) ? 1 : 0;
    eLoad = (v && !dOut && f[1]) ? 1 : 0;
    eClr  = (v && dOut && f[1]) ? 1 : 0;
    chk(tag, "skipReq", skipReq, eSkip);
    chk(tag, "acLoad", acLoad, eLoad);
    chk(tag, "acClear", acClear, eClr);
    if (eLoad != 0) chk(tag, "acData", acData, int'(inData[sel*8 +: 8]));
    chk(tag, "outStrobe", outStrobe, mStrobe);
    chk(tag, "outData", outData, mOutData);
    chk(tag, "inReady", inReady, mIn[0] + 2*mIn[1]);
    chk(tag, "outReady", outReady, mOut[0] + 2*mOut[1]);
    nStr = 0;
    if (eClr != 0) begin nStr = 1 << sel; mOutData = a; end
    if (v && f[2]) begin
      if (dOut) mOut[sel] = 0; else mIn[sel] = 0;
    end
    for (int d = 0; d < 2; d++) begin
      if (iSet[d]) mIn[d] = 1;
      if (oSet[d]) mOut[d] = 1;
    end
    mStrobe = nStr;
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      nFails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    mIn[0] = 0; mIn[1] = 0; mOut[0] = 0; mOut[1] = 0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    inData = 16'hB7_3C;
    // R1: reset state
    step(0, 5'b00000, 8'h00, 2'b00, 2'b00, "R1");
    // R3: skip on clear flag gives no skip
    step(1, 5'b00001, 8'h00, 2'b00, 2'b00, "R3");
    // R2: device 0 raises input flag
    step(0, 5'b00000, 8'h00, 2'b01, 2'b00, "R2");
    step(1, 5'b00001, 8'h00, 2'b00, 2'b00, "R3");   // skip dev0: yes
    step(1, 5'b01001, 8'h00, 2'b00, 2'b00, "R3");   // skip dev1: no
    step(1, 5'b10001, 8'h00, 2'b00, 2'b00, "R3");   // output dev0: no
    // R4: plain read device 0, then device 1
    step(1, 5'b00010, 8'h00, 2'b00, 2'b00, "R4");
    step(1, 5'b01010, 8'h00, 2'b00, 2'b00, "R4");
    // R7: read and clear in one instruction, then flag tested clear
    step(1, 5'b00110, 8'h00, 2'b00, 2'b00, "R7");
    step(1, 5'b00001, 8'h00, 2'b00, 2'b00, "R7");
    // R5: output device 1 ready, write A5, strobe next cycle
    step(0, 5'b00000, 8'h00, 2'b00, 2'b10, "R2");
    step(1, 5'b11011, 8'hA5, 2'b00, 2'b00, "R5");
    step(0, 5'b00000, 8'h11, 2'b00, 2'b00, "R5");
    step(0, 5'b00000, 8'h22, 2'b00, 2'b00, "R5");
    // R6: write and clear device 1, others untouched
    step(0, 5'b00000, 8'h00, 2'b11, 2'b01, "R2");
    step(1, 5'b11110, 8'h5A, 2'b00, 2'b00, "R6");
    step(0, 5'b00000, 8'h00, 2'b00, 2'b00, "R6");
    // R8: set pulse coincides with clear of input dev1
    step(1, 5'b01100, 8'h00, 2'b10, 2'b00, "R8");
    step(1, 5'b01001, 8'h00, 2'b00, 2'b00, "R8");
    // R9: full field with no execute strobe
    step(0, 5'b11111, 8'hFF, 2'b00, 2'b00, "R9");
    step(0, 5'b01111, 8'hFF, 2'b00, 2'b00, "R9");
    step(0, 5'b00000, 8'h00, 2'b00, 2'b00, "R9");
    // R10: input transfer beside output flags
    step(1, 5'b00111, 8'h77, 2'b00, 2'b00, "R10");
    step(0, 5'b00000, 8'h00, 2'b00, 2'b00, "R10");
    // random mix
    for (int k = 0; k < 400; k++) begin
      inData = 16'($urandom);
      step(1'($urandom_range(0, 1)), 5'($urandom), 8'($urandom),
           2'($urandom_range(0, 3) == 0 ? $urandom : 0),
           2'($urandom_range(0, 3) == 0 ? $urandom : 0), "R3/R4/R5/R6/R10");
    end
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end
endmodule